// File: doc/BRIEF.md
# RMII Frame Receiver and Bus Transaction Decoder

This block sits behind a 100 Mbps Ethernet PHY on the reduced media independent interface. It runs entirely on the 50 MHz PHY reference clock, which also clocks the internal bus. While the carrier/data-valid input is high, it collects two receive bits per clock and builds bytes from them. It then checks the sync pattern and the start delimiter. After that it filters the frame on its destination address and on a fixed protocol type of 0x88B5.

Each accepted frame has a fixed length and carries one five-byte bus transaction at the start of its payload. The payload is padded to the 46-byte minimum. The whole frame is covered by a CRC-32. When the frame ends, the block issues one single-cycle request on a simple bus, marked as a read or a write. For a read, a second strobe in the same cycle tells the transmit side that a reply is owed. Frames that fail any check leave no trace on the outputs.

Top module: `rmii_txn_rx`

## Requirements
- R1: While `crs_dv_i` is high, one dibit is taken from `rxd_i` on each clock. Four consecutive dibits form one byte, and the first dibit becomes bits [1:0] of that byte.
- R2: A frame must open with seven 0x55 bytes followed by one 0xD5 byte. A frame with any other opening byte is dropped.
- R3: The first six bytes after the delimiter are the destination. They must equal `LOCAL_MAC`, sent most significant byte first, or must all be 0xFF. Otherwise the frame is dropped.
- R4: Bytes 12 and 13 after the delimiter must be 0x88 and then 0xB5. A frame with any other type is dropped.
- R5: Byte 14 is the command: 0x00 means read and 0x01 means write, and any other value drops the frame. Bytes 15 and 16 are the address and bytes 17 and 18 are the data, each most significant byte first. Both appear on `addr_o` and `wdata_o`.
- R6: The 41 pad bytes that follow the transaction may hold any value. Their contents change nothing except through the CRC.
- R7: The last four bytes carry the complement of a reflected CRC-32 (polynomial 0xEDB88320, seed 0xFFFFFFFF), least significant byte first. The CRC covers everything from the destination through the pad. A frame whose CRC does not match is dropped.
- R8: A frame is accepted only if exactly 64 whole bytes follow the delimiter. A shorter frame, a longer frame, or one that ends with a partial byte is dropped.
- R9: An accepted frame raises `req_o` for exactly one cycle, within eight cycles of `crs_dv_i` falling. `we_o`, `addr_o` and `wdata_o` are valid in that same cycle, and a dropped frame raises no strobe.
- R10: `rd_reply_o` pulses together with `req_o` for a read. It stays low for a write.
- R11: Two frames separated by a single low cycle of `crs_dv_i` are both decoded.
- R12: After reset, `req_o` and `rd_reply_o` are low until the first accepted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 50 MHz PHY reference clock, shared with the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| crs_dv_i | input | 1 | Carrier sense / receive data valid from the PHY |
| rxd_i | input | 2 | Receive dibit from the PHY |
| req_o | output | 1 | Single-cycle bus request strobe |
| we_o | output | 1 | 1 = write, 0 = read, valid with `req_o` |
| addr_o | output | 16 | Bus address, valid with `req_o` |
| wdata_o | output | 16 | Bus write data, valid with `req_o` |
| rd_reply_o | output | 1 | Strobe asking the transmitter to send a read reply |

## Verification
Two things can fall in the same clock window. One is the accept decision and request strobe for a finished frame. The other is the arrival of the first dibits of the next frame. The bench provokes this by sending two frames with only one low cycle of `crs_dv_i` between them, and it requires two strobes whose latched fields belong to the second frame. Both sweeps alternate reads and writes and send frames to the local and to the broadcast address. Each drop condition is sent once with a CRC that is otherwise correct, so that a single cause is isolated.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;
  localparam int unsigned PRE_BYTES   = 7;
  localparam int unsigned MAC_BYTES   = 6;
  localparam int unsigned HDR_BYTES   = 2 * MAC_BYTES + 2;
  localparam int unsigned TXN_BYTES   = 5;
  localparam int unsigned MIN_PAYLOAD = 46;
  localparam int unsigned PAD_BYTES   = MIN_PAYLOAD - TXN_BYTES;
  localparam int unsigned FCS_BYTES   = 4;
  localparam int unsigned FRAME_BYTES = HDR_BYTES + MIN_PAYLOAD + FCS_BYTES;
  localparam int unsigned IDX_W       = $clog2(FRAME_BYTES + 1) + 1;
  localparam int unsigned PIDX_W      = $clog2(PRE_BYTES + 1);
  localparam int unsigned TYPE_OFS    = 2 * MAC_BYTES;
  localparam int unsigned CMD_OFS     = HDR_BYTES;
  localparam int unsigned ADDR_OFS    = CMD_OFS + 1;
  localparam int unsigned DATA_OFS    = ADDR_OFS + 2;
  localparam logic [7:0]  SYNC_BYTE   = 8'h55;
  localparam logic [7:0]  SFD_BYTE    = 8'hD5;
  localparam logic [15:0] ETH_TYPE    = 16'h88B5;
  localparam logic [7:0]  CMD_RD      = 8'h00;
  localparam logic [7:0]  CMD_WR      = 8'h01;
  localparam logic [31:0] CRC_POLY    = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED    = 32'hFFFFFFFF;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

  typedef enum logic [1:0] {ST_PRE, ST_BODY, ST_DROP} rx_state_e;

  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [15:0] data;
  } bus_req_t;
endpackage

// File: rtl/rmii_dibit_pack.sv
module rmii_dibit_pack #(
  parameter int unsigned DIBIT_W = 2,
  parameter int unsigned BYTE_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               crs_dv_i,
  input  logic [DIBIT_W-1:0] rxd_i,
  output logic               byte_vld_o,
  output logic [BYTE_W-1:0]  byte_o,
  output logic               eof_o,
  output logic               frag_o
);
  localparam int unsigned SLOTS = BYTE_W / DIBIT_W;
  localparam int unsigned CNT_W = $clog2(SLOTS);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sr_q;
  logic              crs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      sr_q       <= '0;
      crs_q      <= 1'b0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      eof_o      <= 1'b0;
      frag_o     <= 1'b0;
    end else begin
      crs_q      <= crs_dv_i;
      byte_vld_o <= 1'b0;
      eof_o      <= crs_q & ~crs_dv_i;
      frag_o     <= crs_q & ~crs_dv_i & (cnt_q != '0);
      if (crs_dv_i) begin
        sr_q  <= {rxd_i, sr_q[BYTE_W-1:DIBIT_W]};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(SLOTS - 1)) begin
          byte_vld_o <= 1'b1;
          byte_o     <= {rxd_i, sr_q[BYTE_W-1:DIBIT_W]};
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  // R1
  byte_from_carrier_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> $past(crs_dv_i));
endmodule

// File: rtl/rmii_crc32.sv
module rmii_crc32 import rmii_rx_pkg::*; #(
  parameter int unsigned CRC_W  = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              en_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] nxt;

  always_comb begin
    nxt = crc_o ^ CRC_W'(byte_i);
    for (int b = 0; b < BYTE_W; b++)
      nxt = nxt[0] ? ((nxt >> 1) ^ CRC_W'(CRC_POLY)) : (nxt >> 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_o <= CRC_W'(CRC_SEED);
    else if (init_i) crc_o <= CRC_W'(CRC_SEED);
    else if (en_i)   crc_o <= nxt;
  end

  // R7
  crc_seeded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(init_i) |-> crc_o == CRC_W'(CRC_SEED));
endmodule

// File: rtl/rmii_rx_parse.sv
module rmii_rx_parse import rmii_rx_pkg::*; #(
  parameter logic [8*MAC_BYTES-1:0] LOCAL_MAC = 48'h02_12_34_56_78_9A
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        byte_vld_i,
  input  logic [7:0]  byte_i,
  input  logic        eof_i,
  input  logic        frag_i,
  input  logic [31:0] crc_i,
  output logic        crc_init_o,
  output logic        crc_en_o,
  output logic        req_o,
  output logic        we_o,
  output logic [15:0] addr_o,
  output logic [15:0] wdata_o,
  output logic        rd_reply_o
);
  rx_state_e          st_q;
  logic [PIDX_W-1:0]  pidx_q;
  logic [IDX_W-1:0]   idx_q;
  logic               mac_hit_q, bc_hit_q, type_ok_q, cmd_ok_q;
  bus_req_t           cur_q;
  logic [7:0]         exp_mac;
  logic               accept;

  always_comb begin
    exp_mac = '0;
    for (int k = 0; k < MAC_BYTES; k++)
      if (idx_q == IDX_W'(k)) exp_mac = LOCAL_MAC[8*(MAC_BYTES-1-k) +: 8];
  end

  assign crc_init_o = (st_q == ST_PRE) && byte_vld_i &&
                      (pidx_q == PIDX_W'(PRE_BYTES)) && (byte_i == SFD_BYTE);
  assign crc_en_o   = (st_q == ST_BODY) && byte_vld_i;
  assign accept     = (st_q == ST_BODY) && !frag_i && (idx_q == IDX_W'(FRAME_BYTES)) &&
                      (mac_hit_q || bc_hit_q) && type_ok_q && cmd_ok_q &&
                      (crc_i == CRC_RESIDUE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_PRE;
      pidx_q     <= '0;
      idx_q      <= '0;
      mac_hit_q  <= 1'b1;
      bc_hit_q   <= 1'b1;
      type_ok_q  <= 1'b1;
      cmd_ok_q   <= 1'b1;
      cur_q      <= '0;
      req_o      <= 1'b0;
      rd_reply_o <= 1'b0;
      we_o       <= 1'b0;
      addr_o     <= '0;
      wdata_o    <= '0;
    end else begin
      req_o      <= 1'b0;
      rd_reply_o <= 1'b0;
      if (eof_i) begin
        req_o      <= accept;
        rd_reply_o <= accept && !cur_q.we;
        if (accept) begin
          we_o    <= cur_q.we;
          addr_o  <= cur_q.addr;
          wdata_o <= cur_q.data;
        end
        st_q      <= ST_PRE;
        pidx_q    <= '0;
        idx_q     <= '0;
        mac_hit_q <= 1'b1;
        bc_hit_q  <= 1'b1;
        type_ok_q <= 1'b1;
        cmd_ok_q  <= 1'b1;
      end else if (byte_vld_i) begin
        unique case (st_q)
          ST_PRE: begin
            if (pidx_q == PIDX_W'(PRE_BYTES))
              st_q <= (byte_i == SFD_BYTE) ? ST_BODY : ST_DROP;
            else if (byte_i == SYNC_BYTE)
              pidx_q <= pidx_q + 1'b1;
            else
              st_q <= ST_DROP;
          end
          ST_BODY: begin
            if (idx_q != '1) idx_q <= idx_q + 1'b1;
            if (idx_q < IDX_W'(MAC_BYTES)) begin
              if (byte_i != exp_mac) mac_hit_q <= 1'b0;
              if (byte_i != 8'hFF)   bc_hit_q  <= 1'b0;
            end
            if (idx_q == IDX_W'(TYPE_OFS) && byte_i != ETH_TYPE[15:8]) type_ok_q <= 1'b0;
            if (idx_q == IDX_W'(TYPE_OFS + 1) && byte_i != ETH_TYPE[7:0]) type_ok_q <= 1'b0;
            if (idx_q == IDX_W'(CMD_OFS)) begin
              cmd_ok_q  <= (byte_i == CMD_RD) || (byte_i == CMD_WR);
              cur_q.we  <= (byte_i == CMD_WR);
            end
            if (idx_q == IDX_W'(ADDR_OFS))     cur_q.addr[15:8] <= byte_i;
            if (idx_q == IDX_W'(ADDR_OFS + 1)) cur_q.addr[7:0]  <= byte_i;
            if (idx_q == IDX_W'(DATA_OFS))     cur_q.data[15:8] <= byte_i;
            if (idx_q == IDX_W'(DATA_OFS + 1)) cur_q.data[7:0]  <= byte_i;
          end
          default: ;
        endcase
      end
    end
  end

  // R9
  req_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
  // R9
  req_after_eof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> $past(eof_i));
  // R7
  req_crc_good_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> $past(crc_i) == CRC_RESIDUE);
  // R10
  reply_only_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_reply_o |-> req_o && !we_o);
endmodule

// File: rtl/rmii_txn_rx.sv
module rmii_txn_rx import rmii_rx_pkg::*; #(
  parameter logic [47:0] LOCAL_MAC = 48'h02_12_34_56_78_9A
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        crs_dv_i,
  input  logic [1:0]  rxd_i,
  output logic        req_o,
  output logic        we_o,
  output logic [15:0] addr_o,
  output logic [15:0] wdata_o,
  output logic        rd_reply_o
);
  logic        byte_vld, eof, frag, crc_init, crc_en;
  logic [7:0]  rx_byte;
  logic [31:0] crc;

  rmii_dibit_pack #(.DIBIT_W(2), .BYTE_W(8)) u_pack (
    .clk_i, .rst_ni, .crs_dv_i, .rxd_i,
    .byte_vld_o(byte_vld), .byte_o(rx_byte), .eof_o(eof), .frag_o(frag)
  );

  rmii_crc32 #(.CRC_W(32), .BYTE_W(8)) u_crc (
    .clk_i, .rst_ni, .init_i(crc_init), .en_i(crc_en), .byte_i(rx_byte), .crc_o(crc)
  );

  rmii_rx_parse #(.LOCAL_MAC(LOCAL_MAC)) u_parse (
    .clk_i, .rst_ni, .byte_vld_i(byte_vld), .byte_i(rx_byte), .eof_i(eof),
    .frag_i(frag), .crc_i(crc), .crc_init_o(crc_init), .crc_en_o(crc_en),
    .req_o, .we_o, .addr_o, .wdata_o, .rd_reply_o
  );
endmodule

// File: tb/rmii_txn_rx_tb_top.sv
`timescale 1ns/1ps
module rmii_txn_rx_tb_top;
  localparam logic [47:0] MY_MAC = 48'h02_12_34_56_78_9A;
  localparam logic [47:0] BCAST  = 48'hFF_FF_FF_FF_FF_FF;

  logic clk = 1'b0, rst_n = 1'b0, crs = 1'b0;
  logic [1:0] rxd = 2'b00;
  logic req, we, rdr;
  logic [15:0] addr, wdata;

  always #5 clk = ~clk;

  rmii_txn_rx #(.LOCAL_MAC(MY_MAC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .crs_dv_i(crs), .rxd_i(rxd),
    .req_o(req), .we_o(we), .addr_o(addr), .wdata_o(wdata), .rd_reply_o(rdr)
  );

  int checks = 0, fails = 0;
  int n_req = 0, n_rd = 0, run = 0, max_run = 0;
  logic s_we; logic [15:0] s_addr, s_data;
  logic [7:0] frm [0:127];
  int flen;

  always @(negedge clk) if (rst_n) begin
    if (req) begin n_req++; s_we = we; s_addr = addr; s_data = wdata; end
    if (rdr) n_rd++;
    run = req ? run + 1 : 0;
    if (run > max_run) max_run = run;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_of(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'h0, frm[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

  task automatic mk(input logic [47:0] dst, input logic [15:0] typ, input logic [7:0] cmd,
                    input logic [15:0] a, input logic [15:0] d, input logic [7:0] pad,
                    input int plen);
    logic [31:0] c;
    int n;
    for (int k = 0; k < 6; k++) frm[k] = dst[8*(5-k) +: 8];
    for (int k = 0; k < 6; k++) frm[6+k] = 8'h02 + 8'(k);
    frm[12] = typ[15:8]; frm[13] = typ[7:0];
    frm[14] = cmd; frm[15] = a[15:8]; frm[16] = a[7:0];
    frm[17] = d[15:8]; frm[18] = d[7:0];
    n = 19 + plen;
    for (int k = 19; k < n; k++) frm[k] = pad;
    c = ~crc_of(n);
    for (int k = 0; k < 4; k++) frm[n+k] = c[8*k +: 8];
    flen = n + 4;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); crs = 1'b1; rxd = b[2*i +: 2];
    end
  endtask

  task automatic send(input logic [7:0] pre3, input logic [7:0] sfd, input int extra);
    for (int i = 0; i < 7; i++) send_byte(i == 3 ? pre3 : 8'h55);
    send_byte(sfd);
    for (int i = 0; i < flen; i++) send_byte(frm[i]);
    for (int i = 0; i < extra; i++) begin @(negedge clk); rxd = 2'b11; end
    @(negedge clk); crs = 1'b0; rxd = 2'b00;
  endtask

  task automatic drop_case(input string tag, input logic [7:0] pre3, input logic [7:0] sfd,
                           input int extra);
    int b = n_req;
    send(pre3, sfd, extra);
    repeat (8) @(negedge clk);
    chk(tag, n_req - b, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int br, bd;
    logic [15:0] a, d;
    logic w;
    repeat (3) @(negedge clk);
    chk("R12 req after reset", req, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 no strobe idle", n_req + n_rd, 0);

    // R1 R3 R5 R9 R10: sweep of read/write, local/broadcast, varied fields
    for (int i = 0; i < 8; i++) begin
      a = 16'hA5C3 ^ 16'(i * 16'h1357);
      d = ~a + 16'(i);
      w = i[0];
      mk(i[1] ? BCAST : MY_MAC, 16'h88B5, {7'h0, w}, a, d, 8'h00, 41);
      br = n_req; bd = n_rd;
      send(8'h55, 8'hD5, 0);
      repeat (8) @(negedge clk);
      chk("R9 one req", n_req - br, 1);
      chk("R5 we", s_we, w);
      chk("R1 R5 addr", s_addr, a);
      chk("R5 wdata", s_data, d);
      chk("R10 reply", n_rd - bd, w ? 0 : 1);
    end
    chk("R9 strobe width", max_run, 1);

    // R6: non-zero pad still accepted
    mk(MY_MAC, 16'h88B5, 8'h01, 16'h1234, 16'hBEEF, 8'h3C, 41);
    br = n_req; send(8'h55, 8'hD5, 0); repeat (8) @(negedge clk);
    chk("R6 pad ignored", n_req - br, 1);
    chk("R6 addr", s_addr, 16'h1234);

    mk(MY_MAC ^ 48'h1, 16'h88B5, 8'h01, 16'h1, 16'h2, 8'h00, 41);
    drop_case("R3 wrong dest", 8'h55, 8'hD5, 0);
    mk(MY_MAC, 16'h0800, 8'h01, 16'h1, 16'h2, 8'h00, 41);
    drop_case("R4 wrong type", 8'h55, 8'hD5, 0);
    mk(MY_MAC, 16'h88B5, 8'h02, 16'h1, 16'h2, 8'h00, 41);
    drop_case("R5 bad cmd", 8'h55, 8'hD5, 0);
    mk(MY_MAC, 16'h88B5, 8'h01, 16'h1, 16'h2, 8'h00, 41);
    frm[25] = frm[25] ^ 8'h10;
    drop_case("R7 bad crc", 8'h55, 8'hD5, 0);
    mk(MY_MAC, 16'h88B5, 8'h01, 16'h1, 16'h2, 8'h00, 41);
    drop_case("R2 bad sync", 8'h54, 8'hD5, 0);
    drop_case("R2 bad delimiter", 8'h55, 8'hD4, 0);
    drop_case("R8 partial byte", 8'h55, 8'hD5, 1);
    mk(MY_MAC, 16'h88B5, 8'h01, 16'h1, 16'h2, 8'h00, 40);
    drop_case("R8 short", 8'h55, 8'hD5, 0);
    mk(MY_MAC, 16'h88B5, 8'h01, 16'h1, 16'h2, 8'h00, 42);
    drop_case("R8 long", 8'h55, 8'hD5, 0);

    // R11: two frames, one low cycle between
    br = n_req; bd = n_rd;
    mk(MY_MAC, 16'h88B5, 8'h00, 16'h0F0F, 16'h0000, 8'h00, 41);
    send(8'h55, 8'hD5, 0);
    mk(BCAST, 16'h88B5, 8'h01, 16'h7E81, 16'hC001, 8'h00, 41);
    send(8'h55, 8'hD5, 0);
    repeat (8) @(negedge clk);
    chk("R11 both decoded", n_req - br, 2);
    chk("R11 one reply", n_rd - bd, 1);
    chk("R11 last addr", s_addr, 16'h7E81);
    chk("R11 last data", s_data, 16'hC001);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule